// File: doc/BRIEF.md
# Vector Register-Group Configuration Unit

This unit sets up the register group that a vector core uses for its next operation. The core's groups may span any whole number of physical vector registers, not just a power of two. A configuration request carries three things: a starting register index, the logical vector length in elements, and the element width. The unit then finds how many physical registers the whole vector needs. It also works out the last register index of the group and the element capacity of the group. If the group fits inside the physical register file, these values are committed to status registers.

A request that would run past the last physical register is refused. The refusal raises an error flag, and the previously committed configuration stays in place. The granted length always equals the requested length, so software handles the whole logical vector in one pass with no chunking loop. When the last register of the group is only partly filled, the request is still accepted normally.

Top module: `vrg_cfg_unit`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is low for the cycle after a request is taken. On the next edge the status registers update, and `done` is high for exactly the one cycle that follows that edge.
- R2: The group size equals ceil(len × width / VLEN) with VLEN = 128 bits. The width code on `req_ew` is 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64.
- R3: A request with a length of 0 gets a group size of 1.
- R4: The tail index equals head + group size − 1. The head is a 13-bit index taken from the request.
- R5: The granted length `cfg_vl` equals the requested length. `cfg_cap` equals group size × VLEN / width, is never below `cfg_vl`, and a partly filled last register is not an error.
- R6: If the tail would exceed NUM_PREGS − 1 (1023), `err` goes high and head, tail, size, length, capacity and width all keep their previous values. An accepted request clears `err`.
- R7: After reset: head 0, tail 0, size 1, length 0, width code 0, capacity 16, `err` low, `done` low, `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Unit can take a request |
| req_head | input | HEAD_W (13) | First physical register of the group |
| req_len | input | LEN_W (16) | Logical vector length in elements |
| req_ew | input | 2 | Element width code |
| done | output | 1 | One-cycle pulse when a request has been resolved |
| err | output | 1 | Last request was refused for running past the register file |
| cfg_head | output | HEAD_W (13) | Committed head index |
| cfg_tail | output | HEAD_W (13) | Committed tail index |
| cfg_gsize | output | G_W (16) | Committed group size in registers |
| cfg_vl | output | LEN_W (16) | Granted vector length |
| cfg_cap | output | CAP_W (20) | Element capacity of the committed group |
| cfg_ew | output | 2 | Committed element width code |

## Verification
The sweep covers lengths from zero up to several multiples of one register, at every element width. This catches a rounding step that drops the round-up, because such a design gives one register too few whenever the last register is only partly filled. It also catches a missing floor at one, which would give a zero-size group and a tail below the head for a zero length. Heads are stepped across the 1023 boundary to expose an off-by-one in the range test, either accepting a group one register too long or refusing one that fits exactly. Refused requests are followed by checks that every status field kept its earlier value, and large head values confirm that the upper index bits are not truncated.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;
endpackage

// File: rtl/vrg_sizer.sv
module vrg_sizer #(
  parameter int LEN_W   = 16,
  parameter int VLEN_LG = 7,
  parameter int G_W     = 16,
  parameter int CAP_W   = 20
) (
  input  logic [LEN_W-1:0] len,
  input  vrg_pkg::ew_e     ew,
  output logic [G_W-1:0]   gsize,
  output logic [CAP_W-1:0] cap
);
  localparam int BIT_W = LEN_W + 6;
  localparam int SUM_W = BIT_W + 1;

  logic [2:0]       sh;
  logic [BIT_W-1:0] bits;
  logic [SUM_W-1:0] rounded;
  logic [G_W-1:0]   g_raw;

  always_comb begin
    sh      = 3'd3 + {1'b0, ew};
    bits    = BIT_W'(len) << sh;
    rounded = {1'b0, bits} + SUM_W'((1 << VLEN_LG) - 1);
    g_raw   = G_W'(rounded >> VLEN_LG);
    gsize   = (g_raw == '0) ? G_W'(1) : g_raw;
    cap     = (CAP_W'(gsize) << (VLEN_LG - 3)) >> ew;
  end
endmodule

// File: rtl/vrg_bounds.sv
module vrg_bounds #(
  parameter int HEAD_W    = 13,
  parameter int G_W       = 16,
  parameter int NUM_PREGS = 1024,
  parameter int T_W       = 17
) (
  input  logic [HEAD_W-1:0] head,
  input  logic [G_W-1:0]    gsize,
  output logic [T_W-1:0]    tail,
  output logic              fits
);
  always_comb begin
    tail = T_W'(head) + T_W'(gsize) - T_W'(1);
    fits = (tail < T_W'(NUM_PREGS));
  end
endmodule

// File: rtl/vrg_status.sv
module vrg_status #(
  parameter int HEAD_W = 13,
  parameter int LEN_W  = 16,
  parameter int G_W    = 16,
  parameter int CAP_W  = 20,
  parameter int T_W    = 17,
  parameter int NUM_PREGS = 1024,
  parameter int RST_CAP   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic              fits,
  input  logic [HEAD_W-1:0] n_head,
  input  logic [T_W-1:0]    n_tail,
  input  logic [G_W-1:0]    n_gsize,
  input  logic [LEN_W-1:0]  n_vl,
  input  logic [CAP_W-1:0]  n_cap,
  input  vrg_pkg::ew_e      n_ew,
  output logic              done,
  output logic              err,
  output logic [HEAD_W-1:0] head,
  output logic [HEAD_W-1:0] tail,
  output logic [G_W-1:0]    gsize,
  output logic [LEN_W-1:0]  vl,
  output logic [CAP_W-1:0]  cap,
  output vrg_pkg::ew_e      ew
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      err   <= 1'b0;
      head  <= '0;
      tail  <= '0;
      gsize <= G_W'(1);
      vl    <= '0;
      cap   <= CAP_W'(RST_CAP);
      ew    <= vrg_pkg::EW8;
    end else begin
      done <= commit;
      if (commit) begin
        err <= ~fits;
        if (fits) begin
          head  <= n_head;
          tail  <= HEAD_W'(n_tail);
          gsize <= n_gsize;
          vl    <= n_vl;
          cap   <= n_cap;
          ew    <= n_ew;
        end
      end
    end
  end

  p_gsize_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    gsize != '0);
  p_tail_span_r4: assert property (@(posedge clk) disable iff (rst)
    T_W'(tail) == T_W'(head) + T_W'(gsize) - T_W'(1));
  p_cap_covers_r5: assert property (@(posedge clk) disable iff (rst)
    CAP_W'(vl) <= cap);
  p_tail_inside_r6: assert property (@(posedge clk) disable iff (rst)
    T_W'(tail) < T_W'(NUM_PREGS));
  p_hold_on_reject_r6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> ($stable(head) && $stable(gsize) && $stable(vl)));
endmodule

// File: rtl/vrg_cfg_unit.sv
module vrg_cfg_unit #(
  parameter int HEAD_W    = 13,
  parameter int LEN_W     = 16,
  parameter int VLEN      = 128,
  parameter int NUM_PREGS = 1024,
  localparam int VLEN_LG  = $clog2(VLEN),
  localparam int BIT_W    = LEN_W + 6,
  localparam int G_W      = BIT_W + 1 - VLEN_LG,
  localparam int CAP_W    = G_W + VLEN_LG - 3,
  localparam int T_W      = ((HEAD_W > G_W) ? HEAD_W : G_W) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HEAD_W-1:0] req_head,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_ew,
  output logic              done,
  output logic              err,
  output logic [HEAD_W-1:0] cfg_head,
  output logic [HEAD_W-1:0] cfg_tail,
  output logic [G_W-1:0]    cfg_gsize,
  output logic [LEN_W-1:0]  cfg_vl,
  output logic [CAP_W-1:0]  cfg_cap,
  output logic [1:0]        cfg_ew
);
  import vrg_pkg::*;

  logic              pending;
  logic [HEAD_W-1:0] s_head;
  logic [LEN_W-1:0]  s_len;
  ew_e               s_ew;
  logic              accept;
  logic [G_W-1:0]    c_gsize;
  logic [CAP_W-1:0]  c_cap;
  logic [T_W-1:0]    c_tail;
  logic              c_fits;
  ew_e               st_ew;

  assign req_ready = ~pending;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      s_head  <= '0;
      s_len   <= '0;
      s_ew    <= EW8;
    end else begin
      pending <= accept;
      if (accept) begin
        s_head <= req_head;
        s_len  <= req_len;
        s_ew   <= ew_e'(req_ew);
      end
    end
  end

  vrg_sizer #(.LEN_W(LEN_W), .VLEN_LG(VLEN_LG), .G_W(G_W), .CAP_W(CAP_W)) u_sizer (
    .len(s_len), .ew(s_ew), .gsize(c_gsize), .cap(c_cap)
  );

  vrg_bounds #(.HEAD_W(HEAD_W), .G_W(G_W), .NUM_PREGS(NUM_PREGS), .T_W(T_W)) u_bounds (
    .head(s_head), .gsize(c_gsize), .tail(c_tail), .fits(c_fits)
  );

  vrg_status #(.HEAD_W(HEAD_W), .LEN_W(LEN_W), .G_W(G_W), .CAP_W(CAP_W), .T_W(T_W),
               .NUM_PREGS(NUM_PREGS), .RST_CAP(VLEN / 8)) u_status (
    .clk(clk), .rst(rst), .commit(pending), .fits(c_fits),
    .n_head(s_head), .n_tail(c_tail), .n_gsize(c_gsize), .n_vl(s_len),
    .n_cap(c_cap), .n_ew(s_ew),
    .done(done), .err(err), .head(cfg_head), .tail(cfg_tail), .gsize(cfg_gsize),
    .vl(cfg_vl), .cap(cfg_cap), .ew(st_ew)
  );

  assign cfg_ew = st_ew;

  p_done_follows_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 done);
  p_busy_after_take_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/vrg_cfg_unit_test.sv
module vrg_cfg_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_head = '0;
  logic [15:0] req_len = '0;
  logic [1:0]  req_ew = '0;
  logic        done, err;
  logic [12:0] cfg_head, cfg_tail;
  logic [15:0] cfg_gsize, cfg_vl;
  logic [19:0] cfg_cap;
  logic [1:0]  cfg_ew;

  int vectors = 0;
  int fails = 0;
  longint e_head = 0, e_tail = 0, e_g = 1, e_vl = 0, e_cap = 16, e_ew = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vrg_cfg_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_head(req_head), .req_len(req_len), .req_ew(req_ew),
    .done(done), .err(err), .cfg_head(cfg_head), .cfg_tail(cfg_tail),
    .cfg_gsize(cfg_gsize), .cfg_vl(cfg_vl), .cfg_cap(cfg_cap), .cfg_ew(cfg_ew)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input bit exp_err);
    chk({req, " err"}, err, exp_err);
    chk({req, " head"}, cfg_head, e_head);
    chk({req, " tail"}, cfg_tail, e_tail);
    chk({req, " gsize"}, cfg_gsize, e_g);
    chk({req, " vl"}, cfg_vl, e_vl);
    chk({req, " cap"}, cfg_cap, e_cap);
    chk({req, " ew"}, cfg_ew, e_ew);
  endtask

  task automatic run(input longint head, input longint len, input int ew);
    longint bits, g, tail, width;
    bit ok;
    width = 8 << ew;
    bits  = len * width;
    g     = (bits + 127) / 128;
    if (g == 0) g = 1;
    tail  = head + g - 1;
    ok    = (tail <= 1023);
    @(negedge clk);
    chk("R1 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_head = 13'(head);
    req_len = 16'(len);
    req_ew = 2'(ew);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 ready low while pending", req_ready, 0);
    chk("R1 done not early", done, 0);
    @(negedge clk);
    chk("R1 done pulse", done, 1);
    if (ok) begin
      e_head = head; e_tail = tail; e_g = g; e_vl = len;
      e_cap = g * 128 / width; e_ew = ew;
    end
    if (ok) check_state(len == 0 ? "R3" : "R2 R4 R5", 1'b0);
    else check_state("R6", 1'b1);
    @(negedge clk);
    chk("R1 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    chk("R7 ready", req_ready, 1);
    chk("R7 done", done, 0);
    check_state("R7", 1'b0);
    // R2 R3 R5: length sweep at every width
    for (int ew = 0; ew < 4; ew++)
      for (int len = 0; len <= 130; len++)
        run(5, len, ew);
    // R4 R6: heads across the upper boundary
    for (int h = 1000; h <= 1030; h++)
      for (int len = 0; len <= 80; len += 16)
        run(h, len, 2);
    // R6: exact fit, one over, large head indices
    run(1020, 64, 3);     // g=32? 64*64/128=32 -> tail 1051 reject
    run(1008, 32, 3);     // g=16 tail 1023 fits
    run(1009, 32, 3);     // tail 1024 reject
    run(4096, 1, 0);      // reject, high head bit
    run(8191, 0, 0);      // reject
    run(0, 16'hFFFF, 0);  // g=4096 reject
    run(0, 2048, 3);      // g=1024 tail 1023 fits
    run(511, 100, 1);     // R4 mid head
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule